// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block gathers interrupt events from external pins and internal event lines. It holds a sticky flag for each source, and it presents one request to a processor core together with the address the core must jump to. Each source has an enable bit and a priority bit. Source 0 is the exception: it has no priority bit and always counts as high priority. Two global bits and a mode bit decide which pending flags may actually interrupt. External pins pass through a two-stage synchroniser and an edge detector whose polarity is chosen per pin. A wake output tells a sleeping core that an enabled event has arrived, whatever the global bits say.

Software reaches the state through a four-register bus: enables, priorities, flags and control. The core reports that it has taken the presented request on `irq_ack_i`. The controller then clears the global bit that guards that level. The core reports the end of a handler on `iret_i`, and the controller restores that bit. High-priority service cannot nest. A low-priority handler can allow further low-priority requests by setting its global bit again, and a high-priority request can interrupt it at any time.

Register map (`addr_i`): 0 = enable, 1 = priority, 2 = flags, 3 = control. Control bits: bit 0 = priority mode, bit 1 = high/master global enable, bit 2 = low/peripheral global enable, bits 3 and up = edge polarity per pin, where 1 selects rising and 0 selects falling. Source numbering: bits 0..N_EXT-1 are the pins, and the bits above them are the event lines `evt_i`.

Top module: `irq_ctrl_top`

## Requirements
- R1: In priority mode, a high-priority request presents vector 0x0008 and a low-priority request presents 0x0018. With no request, `irq_vec_o` is 0.
- R2: A pin edge of the polarity selected by control bit 3+k sets flag k, which reads 1 three clock edges after the pin changes. One edge sets the flag once, and an edge of the other polarity sets nothing.
- R3: A pulse on `evt_i[j]` sets flag N_EXT+j at the next clock edge.
- R4: A write to the flags register clears each bit written 0 and leaves each bit written 1 unchanged. An event in the same cycle as a clear leaves the flag set.
- R5: Priority bit 0 always reads 1, whatever is written, so source 0 always requests at high priority.
- R6: In priority mode, a flagged source requests only if it is enabled. A high request also needs control bit 1, and a low request needs both control bits 1 and 2.
- R7: In legacy mode (control bit 0 = 0), pin sources need control bit 1 only, event sources need control bits 1 and 2, and every request presents 0x0008.
- R8: When high-priority and low-priority sources are both pending, the high-priority vector is presented.
- R9: Acknowledging a 0x0008 request clears control bit 1 and masks both levels. Acknowledging a 0x0018 request clears only control bit 2. `iret_i` sets control bit 1 again if a high-priority service is open, and otherwise sets control bit 2.
- R10: During low-priority service, a high-priority request is presented. Software that sets control bit 2 again lets a pending low-priority request be presented.
- R11: `wake_o` equals `sleep_i` AND the OR of (flag AND enable) over all sources, with no dependence on the global bits.
- R12: After reset, enables, flags and the mode and global bits are 0, priority reads 0x01, every polarity bit is 1, and no request or wake is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | N_EXT | External interrupt pins, asynchronous |
| evt_i | input | N_EVT | Internal event pulses, one cycle each |
| sleep_i | input | 1 | Core is sleeping |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select for read and write |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data of the selected register |
| irq_req_o | output | 1 | Request to the core |
| irq_vec_o | output | VW | Vector of the presented request |
| irq_ack_i | input | 1 | Core takes the presented request |
| iret_i | input | 1 | Core leaves the current handler |
| wake_o | output | 1 | Wake-up for a sleeping core |

## Verification
Request, vector, wake and read data are combinational functions of registered state, so they are valid in the same cycle as the edge that updates that state. An event pulse or a register write shows on the next edge. An acknowledge or return changes the global bits one edge later. A pin change reaches its flag on the third edge because of the synchroniser and the edge compare. The bench drives inputs on falling edges and samples on falling edges, after exactly that many rising edges. It reads the flag register at the second and third edges after a pin change, so an extra or missing stage is detected.

// File: rtl/irq_pkg.sv
package irq_pkg;

    typedef enum logic [1:0] {
        REG_EN   = 2'd0,
        REG_PRIO = 2'd1,
        REG_FLAG = 2'd2,
        REG_CTRL = 2'd3
    } irq_reg_e;

    localparam int CTRL_MODE = 0;
    localparam int CTRL_GHI  = 1;
    localparam int CTRL_GLO  = 2;
    localparam int CTRL_POL  = 3;

endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
    parameter int N = 3
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] pin_i,
    input  logic [N-1:0] rise_sel_i,
    output logic [N-1:0] edge_o
);

    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
        logic [N-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = pin_i;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
        edge_o    = (rise_sel_i & st_q.s2 & ~st_q.prev)
                  | (~rise_sel_i & ~st_q.s2 & st_q.prev);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    for (genvar i = 0; i < N; i++) begin : g_once
        // R2: a single transition yields one pulse while the polarity is held
        p_single_edge_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            edge_o[i] ##1 $stable(rise_sel_i[i]) |-> !edge_o[i])
            else $error("p_single_edge_r2");
    end

endmodule

// File: rtl/irq_resolve.sv
module irq_resolve #(
    parameter int N_EXT = 3,
    parameter int N_EVT = 3,
    parameter int VW = 16,
    parameter logic [VW-1:0] VEC_HI = 16'h0008,
    parameter logic [VW-1:0] VEC_LO = 16'h0018
) (
    input  logic [N_EXT+N_EVT-1:0] flag_i,
    input  logic [N_EXT+N_EVT-1:0] en_i,
    input  logic [N_EXT+N_EVT-1:0] prio_i,
    input  logic                   mode_i,
    input  logic                   ghi_i,
    input  logic                   glo_i,
    input  logic                   sleep_i,
    output logic                   req_o,
    output logic                   hi_o,
    output logic [VW-1:0]          vec_o,
    output logic                   wake_o
);

    localparam int N_SRC = N_EXT + N_EVT;
    localparam logic [N_SRC-1:0] CORE = N_SRC'((1 << N_EXT) - 1);

    logic [N_SRC-1:0] act;
    logic             hi, lo;

    always_comb begin
        act = flag_i & en_i;
        if (mode_i) begin
            hi = ghi_i & (|(act & prio_i));
            lo = ghi_i & glo_i & (|(act & ~prio_i));
        end else begin
            hi = ghi_i & ((|(act & CORE)) | (glo_i & (|(act & ~CORE))));
            lo = 1'b0;
        end
        req_o  = hi | lo;
        hi_o   = hi;
        vec_o  = hi ? VEC_HI : (lo ? VEC_LO : '0);
        wake_o = sleep_i & (|act);
    end

endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top
    import irq_pkg::*;
#(
    parameter int N_EXT = 3,
    parameter int N_EVT = 3,
    parameter int DW = ((N_EXT + N_EVT) > (N_EXT + 3)) ? (N_EXT + N_EVT) : (N_EXT + 3),
    parameter int VW = 16,
    parameter logic [VW-1:0] VEC_HI = 16'h0008,
    parameter logic [VW-1:0] VEC_LO = 16'h0018
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [N_EXT-1:0] pin_i,
    input  logic [N_EVT-1:0] evt_i,
    input  logic             sleep_i,
    input  logic             wr_en_i,
    input  logic [1:0]       addr_i,
    input  logic [DW-1:0]    wdata_i,
    output logic [DW-1:0]    rdata_o,
    output logic             irq_req_o,
    output logic [VW-1:0]    irq_vec_o,
    input  logic             irq_ack_i,
    input  logic             iret_i,
    output logic             wake_o
);

    localparam int N_SRC = N_EXT + N_EVT;

    typedef struct packed {
        logic [N_SRC-1:0] en;
        logic [N_SRC-1:0] prio;
        logic [N_SRC-1:0] flag;
        logic             mode;
        logic             ghi;
        logic             glo;
        logic [N_EXT-1:0] pol;
        logic             in_hi;
    } st_t;

    st_t              st_d, st_q;
    logic [N_EXT-1:0] ext_edge;
    logic             take_hi;
    irq_reg_e         sel;

    irq_edge_det #(.N(N_EXT)) u_edge (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .pin_i      (pin_i),
        .rise_sel_i (st_q.pol),
        .edge_o     (ext_edge)
    );

    irq_resolve #(
        .N_EXT(N_EXT), .N_EVT(N_EVT), .VW(VW), .VEC_HI(VEC_HI), .VEC_LO(VEC_LO)
    ) u_resolve (
        .flag_i  (st_q.flag),
        .en_i    (st_q.en),
        .prio_i  (st_q.prio),
        .mode_i  (st_q.mode),
        .ghi_i   (st_q.ghi),
        .glo_i   (st_q.glo),
        .sleep_i (sleep_i),
        .req_o   (irq_req_o),
        .hi_o    (take_hi),
        .vec_o   (irq_vec_o),
        .wake_o  (wake_o)
    );

    assign sel = irq_reg_e'(addr_i);

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            case (sel)
                REG_EN:   st_d.en   = wdata_i[N_SRC-1:0];
                REG_PRIO: st_d.prio = wdata_i[N_SRC-1:0];
                REG_FLAG: st_d.flag = st_q.flag & wdata_i[N_SRC-1:0];
                REG_CTRL: begin
                    st_d.mode = wdata_i[CTRL_MODE];
                    st_d.ghi  = wdata_i[CTRL_GHI];
                    st_d.glo  = wdata_i[CTRL_GLO];
                    st_d.pol  = wdata_i[CTRL_POL +: N_EXT];
                end
                default: ;
            endcase
        end
        st_d.prio[0] = 1'b1;
        st_d.flag    = st_d.flag | {evt_i, ext_edge};
        if (irq_ack_i && irq_req_o) begin
            if (take_hi) begin
                st_d.ghi   = 1'b0;
                st_d.in_hi = 1'b1;
            end else begin
                st_d.glo   = 1'b0;
            end
        end
        if (iret_i) begin
            if (st_q.in_hi) begin
                st_d.ghi   = 1'b1;
                st_d.in_hi = 1'b0;
            end else begin
                st_d.glo   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q      <= '0;
            st_q.prio <= N_SRC'(1);
            st_q.pol  <= '1;
        end else begin
            st_q      <= st_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        case (sel)
            REG_EN:   rdata_o[N_SRC-1:0] = st_q.en;
            REG_PRIO: rdata_o[N_SRC-1:0] = st_q.prio;
            REG_FLAG: rdata_o[N_SRC-1:0] = st_q.flag;
            REG_CTRL: begin
                rdata_o[CTRL_MODE]          = st_q.mode;
                rdata_o[CTRL_GHI]           = st_q.ghi;
                rdata_o[CTRL_GLO]           = st_q.glo;
                rdata_o[CTRL_POL +: N_EXT]  = st_q.pol;
            end
            default: ;
        endcase
    end

    p_vec_legacy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_req_o && !st_q.mode) |-> (irq_vec_o == VEC_HI))
        else $error("p_vec_legacy_r7");

    p_src0_hi_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.mode && st_q.ghi && st_q.flag[0] && st_q.en[0])
            |-> (irq_req_o && irq_vec_o == VEC_HI))
        else $error("p_src0_hi_r5");

    p_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !st_q.ghi |-> !irq_req_o)
        else $error("p_gate_r6");

    p_ack_hi_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_ack_i && !iret_i && irq_req_o && irq_vec_o == VEC_HI
            && !(wr_en_i && sel == REG_CTRL))
            |=> (!st_q.ghi && st_q.in_hi))
        else $error("p_ack_hi_r9");

    p_ack_lo_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_ack_i && !iret_i && irq_req_o && irq_vec_o == VEC_LO
            && !(wr_en_i && sel == REG_CTRL))
            |=> (!st_q.glo && st_q.ghi))
        else $error("p_ack_lo_r9");

    p_wake_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sleep_i |-> !wake_o)
        else $error("p_wake_r11");

    for (genvar i = 0; i < N_SRC; i++) begin : g_hold
        p_flag_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (st_q.flag[i] && !(wr_en_i && sel == REG_FLAG && !wdata_i[i]))
                |=> st_q.flag[i])
            else $error("p_flag_hold_r4");
    end

endmodule

// File: tb/irq_ctrl_top_tb_top.sv
`timescale 1ns/1ps
module irq_ctrl_top_tb_top;

    localparam logic [1:0] A_EN = 2'd0, A_PRIO = 2'd1, A_FLAG = 2'd2, A_CTRL = 2'd3;

    typedef struct packed {
        logic [5:0]  ctrl;
        logic [5:0]  en;
        logic [5:0]  prio;
        logic [2:0]  evt;
        logic        req;
        logic [15:0] vec;
        logic        wake;
    } row_t;

    localparam row_t TBL [10] = '{
        '{6'h3A, 6'h08, 6'h00, 3'b001, 1'b0, 16'h0000, 1'b1}, // R7 event source lacks peripheral enable
        '{6'h3E, 6'h08, 6'h00, 3'b001, 1'b1, 16'h0008, 1'b1}, // R7 legacy, both globals
        '{6'h3C, 6'h08, 6'h00, 3'b001, 1'b0, 16'h0000, 1'b1}, // R7 master enable off
        '{6'h3F, 6'h08, 6'h00, 3'b001, 1'b1, 16'h0018, 1'b1}, // R1 low vector
        '{6'h3F, 6'h08, 6'h08, 3'b001, 1'b1, 16'h0008, 1'b1}, // R1 high vector
        '{6'h3B, 6'h08, 6'h00, 3'b001, 1'b0, 16'h0000, 1'b1}, // R6 low needs low global
        '{6'h3D, 6'h08, 6'h08, 3'b001, 1'b0, 16'h0000, 1'b1}, // R6 high needs high global
        '{6'h3F, 6'h18, 6'h10, 3'b011, 1'b1, 16'h0008, 1'b1}, // R8 both levels pending
        '{6'h3F, 6'h00, 6'h00, 3'b001, 1'b0, 16'h0000, 1'b0}, // R6 source disabled
        '{6'h38, 6'h28, 6'h00, 3'b100, 1'b0, 16'h0000, 1'b1}  // R11 wake without globals
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  pin = '0;
    logic [2:0]  evt = '0;
    logic        sleep = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = '0;
    logic [5:0]  wdata = '0;
    logic [5:0]  rdata;
    logic        req;
    logic [15:0] vec;
    logic        ack = 1'b0;
    logic        iret = 1'b0;
    logic        wake;
    int          n_chk = 0;
    int          n_err = 0;
    logic        done = 1'b0;

    always #4 clk = ~clk;

    irq_ctrl_top dut_i (
        .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .evt_i(evt), .sleep_i(sleep),
        .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
        .irq_req_o(req), .irq_vec_o(vec), .irq_ack_i(ack), .iret_i(iret), .wake_o(wake)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [5:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [5:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic pulse_evt(input logic [2:0] e);
        @(negedge clk);
        evt = e;
        @(negedge clk);
        evt = '0;
    endtask

    task automatic pulse_ack();
        @(negedge clk);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic pulse_iret();
        @(negedge clk);
        iret = 1'b1;
        @(negedge clk);
        iret = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [5:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        rd(A_EN, d);   chk("R12 enable", d, 6'h00);
        rd(A_PRIO, d); chk("R12 priority", d, 6'h01);
        rd(A_FLAG, d); chk("R12 flags", d, 6'h00);
        rd(A_CTRL, d); chk("R12 control", d, 6'h38);
        chk("R12 request", req, 0);
        chk("R12 wake", wake, 0);

        // R5 source 0 priority fixed high
        wr(A_PRIO, 6'h00);
        rd(A_PRIO, d); chk("R5 priority bit 0", d, 6'h01);

        // Table walk: R1 R6 R7 R8 R11
        sleep = 1'b1;
        for (int i = 0; i < 10; i++) begin
            wr(A_CTRL, TBL[i].ctrl);
            wr(A_EN, TBL[i].en);
            wr(A_PRIO, TBL[i].prio);
            pulse_evt(TBL[i].evt);
            chk($sformatf("R1/R6/R7/R8 row %0d request", i), req, TBL[i].req);
            if (TBL[i].req) chk($sformatf("R1/R7/R8 row %0d vector", i), vec, TBL[i].vec);
            chk($sformatf("R11 row %0d wake", i), wake, TBL[i].wake);
            wr(A_FLAG, 6'h00);
        end
        sleep = 1'b0;
        chk("R11 no wake when awake", wake, 0);

        // R3 event sets its flag after one edge
        wr(A_CTRL, 6'h38);
        pulse_evt(3'b100);
        rd(A_FLAG, d); chk("R3 event flag", d, 6'h20);

        // R4 write one keeps, clear loses to simultaneous event
        wr(A_FLAG, 6'h3F);
        rd(A_FLAG, d); chk("R4 write one keeps", d, 6'h20);
        wr(A_FLAG, 6'h00);
        @(negedge clk);
        evt = 3'b001; wr_en = 1'b1; addr = A_FLAG; wdata = 6'h00;
        @(negedge clk);
        evt = '0; wr_en = 1'b0;
        rd(A_FLAG, d); chk("R4 event beats clear", d, 6'h08);
        wr(A_FLAG, 6'h00);
        rd(A_FLAG, d); chk("R4 write zero clears", d, 6'h00);

        // R2 rising edge on pin 1 with exact latency
        @(negedge clk); pin[1] = 1'b1;
        @(negedge clk); rd(A_FLAG, d); chk("R2 flag after one edge", d, 6'h00);
        @(negedge clk); rd(A_FLAG, d); chk("R2 flag after two edges", d, 6'h00);
        @(negedge clk); rd(A_FLAG, d); chk("R2 flag after three edges", d, 6'h02);
        // R7 legacy pin source needs only the master enable
        wr(A_EN, 6'h02);
        wr(A_CTRL, 6'h3A);
        chk("R7 legacy pin request", req, 1);
        chk("R7 legacy pin vector", vec, 16'h0008);
        wr(A_FLAG, 6'h00);
        repeat (4) @(negedge clk);
        rd(A_FLAG, d); chk("R2 level does not re-flag", d, 6'h00);

        // R2 falling polarity on pin 2
        wr(A_CTRL, 6'h18);
        @(negedge clk); pin[2] = 1'b1;
        repeat (4) @(negedge clk);
        rd(A_FLAG, d); chk("R2 rise ignored when falling selected", d, 6'h00);
        pin[2] = 1'b0;
        repeat (3) @(negedge clk);
        rd(A_FLAG, d); chk("R2 falling edge flags", d, 6'h04);
        wr(A_FLAG, 6'h00);

        // R9 R10 acknowledge, nesting and return
        wr(A_EN, 6'h08);
        wr(A_PRIO, 6'h00);
        wr(A_CTRL, 6'h3F);
        pulse_evt(3'b001);
        chk("R1 low request", req, 1);
        chk("R1 low vector", vec, 16'h0018);
        pulse_ack();
        rd(A_CTRL, d); chk("R9 low ack clears low global only", d, 6'h3B);
        chk("R9 request masked after low ack", req, 0);
        wr(A_CTRL, 6'h3F);
        chk("R10 low re-enabled request", req, 1);
        chk("R10 low re-enabled vector", vec, 16'h0018);
        pulse_ack();
        wr(A_EN, 6'h18);
        wr(A_PRIO, 6'h10);
        pulse_evt(3'b010);
        chk("R10 high pre-empts low service", req, 1);
        chk("R10 high vector during low service", vec, 16'h0008);
        pulse_ack();
        rd(A_CTRL, d); chk("R9 high ack clears high global", d, 6'h39);
        chk("R9 both levels masked", req, 0);
        pulse_iret();
        rd(A_CTRL, d); chk("R9 return restores high global", d, 6'h3B);
        pulse_iret();
        rd(A_CTRL, d); chk("R9 second return restores low global", d, 6'h3F);
        chk("R8 high still first", vec, 16'h0008);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule